// File: doc/BRIEF.md
# UDP Receive Stream Steering Engine

This block receives an Ethernet frame one byte per clock from a receive MAC and steers it to one of three outcomes. A frame that is not addressed to this station is discarded. A frame that carries a selected UDP stream is offloaded. Any other accepted frame goes whole to a general host path. For an offloaded frame, its 42 header bytes (Ethernet, IPv4 without options, UDP) are written into one circular buffer and its payload bytes into another. Each buffer has its own base address, size and running write offset.

Arriving bytes are held in a frame store until the last byte has been seen. The steering decision is then final, so a receive error or a lack of space can cancel the whole frame. Committed frames are then drained in arrival order. The drain drives one write port per cycle: header ring, payload ring or host stream. After every programmed batch of offloaded frames, one interrupt pulse marks the moment new data is available. The UDP ports that form the selected streams are held in a small table, loaded through a write-only configuration port.

Top module: `udp_stream_steer`

## Requirements
- R1: While reset is held and right after it, no write strobe (`hdr_we`, `pay_we`, `host_we`) and no `irq` is asserted, and `drop_count` is 0.
- R2: A frame is kept only if its first six bytes equal `station_mac` (byte 0 compared with bits 47:40) or bit 0 of byte 0 is 1 (group address). Otherwise it produces no write at all.
- R3: An accepted frame is offloaded only when all of these hold: bytes 12 and 13 are 0x08 and 0x00, byte 14 is 0x45, byte 23 is 0x11, the frame has at least 42 bytes, and bytes 36–37 (high byte first) equal the port of an enabled table entry. Every other accepted frame takes the host path.
- R4: For an offloaded frame, bytes 0 to 41 go to the header ring in order and all later bytes go to the payload ring in order. This includes a 1024-byte payload.
- R5: A host-path frame appears on `host_data` with `host_we` in byte order, and `host_last` is set only with its final byte.
- R6: Each ring write address is base plus an offset. The offset is 0 after reset, advances by one for each byte written to that ring, returns to 0 when it reaches the ring size, and carries over from frame to frame.
- R7: A frame whose last byte comes with `rx_err` high produces no write, whatever its classification.
- R8: A frame that cannot be stored completely is discarded, and `drop_count` rises by exactly one for it. This happens when it has more bytes than the free space in the frame store (2048 bytes by default) or when the frame queue is full. Frames that follow are handled normally.
- R9: `irq` is a one-cycle pulse that comes together with the last ring write of every Nth offloaded frame. N is `irq_batch`, and a value of 0 acts as 1.
- R10: Writing with `cfg_we` loads entry `cfg_idx` with `cfg_port` and `cfg_en`. After reset all entries are disabled, and a disabled entry never matches.
- R11: At most one of the three write strobes is high in any cycle, and frames come out in the order they arrived.
- R12: Frames sent back to back with no idle cycle between them are each steered correctly, and none is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Final byte of the frame |
| rx_err | input | 1 | Receive error, looked at with the final byte |
| station_mac | input | 48 | Own station address |
| cfg_we | input | 1 | Stream table write strobe |
| cfg_idx | input | 2 | Stream table entry index |
| cfg_port | input | 16 | UDP destination port for the entry |
| cfg_en | input | 1 | Entry enable |
| hdr_base | input | 16 | Header ring base address |
| hdr_size | input | 16 | Header ring size in bytes, nonzero |
| pay_base | input | 16 | Payload ring base address |
| pay_size | input | 16 | Payload ring size in bytes, nonzero |
| irq_batch | input | 8 | Offloaded frames per interrupt |
| hdr_we | output | 1 | Header ring write strobe |
| hdr_addr | output | 16 | Header ring write address |
| hdr_data | output | 8 | Header ring write byte |
| pay_we | output | 1 | Payload ring write strobe |
| pay_addr | output | 16 | Payload ring write address |
| pay_data | output | 8 | Payload ring write byte |
| host_we | output | 1 | Host path byte strobe |
| host_data | output | 8 | Host path byte |
| host_last | output | 1 | Final byte of a host frame |
| irq | output | 1 | Batch interrupt pulse |
| drop_count | output | 16 | Frames discarded for lack of space |

## Verification
The store overflow is the hardest case to reach from the ports. The drain keeps pace with the input for ordinary traffic, so the store never fills on its own. The stimulus therefore waits until the block is idle and then sends a single accepted frame longer than the store. Because nothing of an uncommitted frame can drain, this frame must overflow. A normal frame follows to show that recovery works. A back-to-back burst is also sent that mixes an errored frame, a rejected address, offloaded frames and host frames with no idle cycles between them. This checks that a cancelled frame leaves no bytes behind for the frame that follows it.

// File: rtl/udp_steer_pkg.sv
package udp_steer_pkg;
  localparam int RING_W    = 16;
  localparam int CNT_W     = 16;
  localparam int HDR_BYTES = 42;

  typedef struct packed {
    logic       mac_eq;
    logic       grp;
    logic       mac_seen;
    logic       et_hi;
    logic       et_ok;
    logic       ver_ok;
    logic       proto_ok;
    logic [7:0] port_hi;
    logic       hit;
    logic       hdr_seen;
  } parse_t;

  localparam parse_t PARSE_INIT = '{mac_eq: 1'b1, default: '0};

  // next ring offset, wrapping to zero at the ring size
  function automatic logic [RING_W-1:0] ring_step(input logic [RING_W-1:0] off,
                                                  input logic [RING_W-1:0] size);
    return ({1'b0, off} + 17'd1 >= {1'b0, size}) ? '0 : off + 1'b1;
  endfunction

  // true when this offloaded frame completes a batch (batch 0 acts as 1)
  function automatic logic batch_full(input logic [7:0] cnt, input logic [7:0] batch);
    return ({1'b0, cnt} + 9'd1) >= ((batch == 8'd0) ? 9'd1 : {1'b0, batch});
  endfunction
endpackage

// File: rtl/steer_parser.sv
module steer_parser
  import udp_steer_pkg::*;
#(
  parameter int PORTS = 4,
  localparam int IDX_W = (PORTS > 1) ? $clog2(PORTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             rx_last,
  input  logic [47:0]      station_mac,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [15:0]      cfg_port,
  input  logic             cfg_en,
  output logic             mac_ok,
  output logic             stream_hit
);
  logic [5:0]       bcnt;
  parse_t           fl, nx;
  logic [7:0]       mac_byte;
  logic [PORTS-1:0] ent_hit;
  logic [15:0]      port_word;

  assign port_word = {fl.port_hi, rx_data};

  for (genvar g = 0; g < PORTS; g++) begin : g_ent
    logic        en_q;
    logic [15:0] port_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q   <= 1'b0;
        port_q <= '0;
      end else if (cfg_we && cfg_idx == IDX_W'(g)) begin
        en_q   <= cfg_en;
        port_q <= cfg_port;
      end
    end
    assign ent_hit[g] = en_q && (port_q == port_word);
  end

  always_comb begin
    mac_byte = '0;
    for (int i = 0; i < 6; i++)
      if (bcnt == 6'(i)) mac_byte = station_mac[8*(5-i) +: 8];
  end

  always_comb begin
    nx = fl;
    case (bcnt)
      6'd0:  nx.grp      = rx_data[0];
      6'd12: nx.et_hi    = (rx_data == 8'h08);
      6'd13: nx.et_ok    = fl.et_hi && (rx_data == 8'h00);
      6'd14: nx.ver_ok   = (rx_data == 8'h45);
      6'd23: nx.proto_ok = (rx_data == 8'h11);
      6'd36: nx.port_hi  = rx_data;
      6'd37: nx.hit      = |ent_hit;
      default: ;
    endcase
    if (bcnt < 6'd6 && rx_data != mac_byte) nx.mac_eq = 1'b0;
    if (bcnt == 6'd5)  nx.mac_seen = 1'b1;
    if (bcnt == 6'd41) nx.hdr_seen = 1'b1;
  end

  // valid with the final byte of a frame
  assign mac_ok     = nx.mac_seen && (nx.mac_eq || nx.grp);
  assign stream_hit = nx.et_ok && nx.ver_ok && nx.proto_ok && nx.hit && nx.hdr_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt <= '0;
      fl   <= PARSE_INIT;
    end else if (rx_valid) begin
      if (rx_last) begin
        bcnt <= '0;
        fl   <= PARSE_INIT;
      end else begin
        fl <= nx;
        if (bcnt != 6'h3F) bcnt <= bcnt + 6'd1;
      end
    end
  end
endmodule

// File: rtl/steer_fifo.sv
module steer_fifo
  import udp_steer_pkg::*;
#(
  parameter int FIFO_AW  = 11,
  parameter int QUEUE_AW = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             rx_last,
  input  logic             rx_err,
  input  logic             mac_ok,
  input  logic             stream_hit,
  input  logic             pop,
  input  logic             rd_adv,
  output logic             q_valid,
  output logic             q_ring,
  output logic [FIFO_AW:0] q_len,
  output logic [7:0]       rd_data,
  output logic             frame_commit,
  output logic             frame_lost,
  output logic [CNT_W-1:0] drop_count
);
  localparam int DEPTH  = 1 << FIFO_AW;
  localparam int QDEPTH = 1 << QUEUE_AW;
  localparam logic [FIFO_AW:0]  FULL_LVL  = {1'b1, {FIFO_AW{1'b0}}};
  localparam logic [QUEUE_AW:0] QFULL_LVL = {1'b1, {QUEUE_AW{1'b0}}};

  logic [7:0]        mem   [DEPTH];
  logic [FIFO_AW:0]  qlen  [QDEPTH];
  logic              qring [QDEPTH];
  logic [FIFO_AW:0]  wr_ptr, rd_ptr, fstart;
  logic [QUEUE_AW:0] qw, qr;
  logic              ovf_q, room, q_full, byte_wr, end_frame, no_space;

  assign room      = (wr_ptr - rd_ptr) != FULL_LVL;
  assign q_full    = (qw - qr) == QFULL_LVL;
  assign byte_wr   = rx_valid && room && !ovf_q;
  assign end_frame = rx_valid && rx_last;
  assign no_space  = ovf_q || !room || q_full;

  assign frame_lost   = end_frame && no_space;
  assign frame_commit = end_frame && !no_space && !rx_err && mac_ok;

  assign q_valid = (qw != qr);
  assign q_ring  = qring[qr[QUEUE_AW-1:0]];
  assign q_len   = qlen[qr[QUEUE_AW-1:0]];
  assign rd_data = mem[rd_ptr[FIFO_AW-1:0]];

  always_ff @(posedge clk) begin
    if (byte_wr) mem[wr_ptr[FIFO_AW-1:0]] <= rx_data;
    if (frame_commit) begin
      qlen[qw[QUEUE_AW-1:0]]  <= wr_ptr - fstart + 1'b1;
      qring[qw[QUEUE_AW-1:0]] <= stream_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      fstart     <= '0;
      qw         <= '0;
      qr         <= '0;
      ovf_q      <= 1'b0;
      drop_count <= '0;
    end else begin
      if (byte_wr) wr_ptr <= wr_ptr + 1'b1;
      if (rx_valid && !room) ovf_q <= 1'b1;
      if (end_frame) begin
        ovf_q <= 1'b0;
        if (frame_commit) fstart <= wr_ptr + 1'b1;
        else              wr_ptr <= fstart;
      end
      if (frame_commit) qw <= qw + 1'b1;
      if (frame_lost)   drop_count <= drop_count + 1'b1;
      if (rd_adv)       rd_ptr <= rd_ptr + 1'b1;
      if (pop)          qr <= qr + 1'b1;
    end
  end
endmodule

// File: rtl/steer_drain.sv
module steer_drain
  import udp_steer_pkg::*;
#(
  parameter int FIFO_AW = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              q_valid,
  input  logic              q_ring,
  input  logic [FIFO_AW:0]  q_len,
  input  logic [7:0]        rd_data,
  input  logic [RING_W-1:0] hdr_base,
  input  logic [RING_W-1:0] hdr_size,
  input  logic [RING_W-1:0] pay_base,
  input  logic [RING_W-1:0] pay_size,
  input  logic [7:0]        irq_batch,
  output logic              pop,
  output logic              rd_adv,
  output logic              hdr_we,
  output logic [RING_W-1:0] hdr_addr,
  output logic [7:0]        hdr_data,
  output logic              pay_we,
  output logic [RING_W-1:0] pay_addr,
  output logic [7:0]        pay_data,
  output logic              host_we,
  output logic [7:0]        host_data,
  output logic              host_last,
  output logic              irq
);
  localparam logic [FIFO_AW:0] HDR_END = (FIFO_AW+1)'(HDR_BYTES);

  logic              busy, ring_q, last_byte, in_hdr;
  logic [FIFO_AW:0]  len_q, idx;
  logic [RING_W-1:0] hoff, poff;
  logic [7:0]        bcnt;

  assign pop       = !busy && q_valid;
  assign rd_adv    = busy;
  assign last_byte = busy && (idx == len_q - 1'b1);
  assign in_hdr    = idx < HDR_END;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; ring_q <= 1'b0; len_q <= '0; idx <= '0;
      hoff <= '0; poff <= '0; bcnt <= '0;
      hdr_we <= 1'b0; hdr_addr <= '0; hdr_data <= '0;
      pay_we <= 1'b0; pay_addr <= '0; pay_data <= '0;
      host_we <= 1'b0; host_data <= '0; host_last <= 1'b0; irq <= 1'b0;
    end else begin
      hdr_we <= 1'b0; pay_we <= 1'b0; host_we <= 1'b0; host_last <= 1'b0; irq <= 1'b0;
      if (pop) begin
        busy <= 1'b1; ring_q <= q_ring; len_q <= q_len; idx <= '0;
      end
      if (busy) begin
        idx <= idx + 1'b1;
        if (ring_q && in_hdr) begin
          hdr_we <= 1'b1; hdr_addr <= hdr_base + hoff; hdr_data <= rd_data;
          hoff <= ring_step(hoff, hdr_size);
        end else if (ring_q) begin
          pay_we <= 1'b1; pay_addr <= pay_base + poff; pay_data <= rd_data;
          poff <= ring_step(poff, pay_size);
        end else begin
          host_we <= 1'b1; host_data <= rd_data; host_last <= last_byte;
        end
        if (last_byte) begin
          busy <= 1'b0;
          if (ring_q) begin
            if (batch_full(bcnt, irq_batch)) begin
              irq <= 1'b1; bcnt <= '0;
            end else begin
              bcnt <= bcnt + 8'd1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/udp_stream_steer.sv
module udp_stream_steer
  import udp_steer_pkg::*;
#(
  parameter int FIFO_AW  = 11,
  parameter int QUEUE_AW = 2,
  parameter int PORTS    = 4,
  localparam int IDX_W   = (PORTS > 1) ? $clog2(PORTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  input  logic              rx_err,
  input  logic [47:0]       station_mac,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [15:0]       cfg_port,
  input  logic              cfg_en,
  input  logic [RING_W-1:0] hdr_base,
  input  logic [RING_W-1:0] hdr_size,
  input  logic [RING_W-1:0] pay_base,
  input  logic [RING_W-1:0] pay_size,
  input  logic [7:0]        irq_batch,
  output logic              hdr_we,
  output logic [RING_W-1:0] hdr_addr,
  output logic [7:0]        hdr_data,
  output logic              pay_we,
  output logic [RING_W-1:0] pay_addr,
  output logic [7:0]        pay_data,
  output logic              host_we,
  output logic [7:0]        host_data,
  output logic              host_last,
  output logic              irq,
  output logic [CNT_W-1:0]  drop_count
);
  // named internal events, observed by the bound checker
  logic             mac_ok, stream_hit, frame_commit, frame_lost;
  logic             q_valid, q_ring, pop, rd_adv;
  logic [FIFO_AW:0] q_len;
  logic [7:0]       rd_data;

  steer_parser #(.PORTS(PORTS)) u_parser (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
    .station_mac(station_mac), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_port(cfg_port),
    .cfg_en(cfg_en), .mac_ok(mac_ok), .stream_hit(stream_hit)
  );

  steer_fifo #(.FIFO_AW(FIFO_AW), .QUEUE_AW(QUEUE_AW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
    .rx_err(rx_err), .mac_ok(mac_ok), .stream_hit(stream_hit), .pop(pop), .rd_adv(rd_adv),
    .q_valid(q_valid), .q_ring(q_ring), .q_len(q_len), .rd_data(rd_data),
    .frame_commit(frame_commit), .frame_lost(frame_lost), .drop_count(drop_count)
  );

  steer_drain #(.FIFO_AW(FIFO_AW)) u_drain (
    .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_ring(q_ring), .q_len(q_len),
    .rd_data(rd_data), .hdr_base(hdr_base), .hdr_size(hdr_size), .pay_base(pay_base),
    .pay_size(pay_size), .irq_batch(irq_batch), .pop(pop), .rd_adv(rd_adv),
    .hdr_we(hdr_we), .hdr_addr(hdr_addr), .hdr_data(hdr_data),
    .pay_we(pay_we), .pay_addr(pay_addr), .pay_data(pay_data),
    .host_we(host_we), .host_data(host_data), .host_last(host_last), .irq(irq)
  );
endmodule

// File: rtl/steer_checks.sv
module steer_checks
  import udp_steer_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic              rx_last,
  input logic              rx_err,
  input logic              mac_ok,
  input logic              frame_commit,
  input logic              hdr_we,
  input logic [RING_W-1:0] hdr_addr,
  input logic [RING_W-1:0] hdr_base,
  input logic [RING_W-1:0] hdr_size,
  input logic              pay_we,
  input logic [RING_W-1:0] pay_addr,
  input logic [RING_W-1:0] pay_base,
  input logic [RING_W-1:0] pay_size,
  input logic              host_we,
  input logic              host_last,
  input logic              irq,
  input logic [CNT_W-1:0]  drop_count
);
  p_one_sink_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hdr_we, pay_we, host_we}));

  p_hdr_in_ring_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_we |-> (RING_W'(hdr_addr - hdr_base) < hdr_size));

  p_pay_in_ring_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pay_we |-> (RING_W'(pay_addr - pay_base) < pay_size));

  p_last_with_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
    host_last |-> host_we);

  p_irq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_irq_with_ring_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (hdr_we || pay_we));

  p_drop_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(drop_count) |-> drop_count == $past(drop_count) + 1'b1);

  p_err_discard_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_last && rx_err) |-> !frame_commit);

  p_mac_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_last && !mac_ok) |-> !frame_commit);
endmodule

bind udp_stream_steer steer_checks u_checks (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_last(rx_last), .rx_err(rx_err),
  .mac_ok(mac_ok), .frame_commit(frame_commit),
  .hdr_we(hdr_we), .hdr_addr(hdr_addr), .hdr_base(hdr_base), .hdr_size(hdr_size),
  .pay_we(pay_we), .pay_addr(pay_addr), .pay_base(pay_base), .pay_size(pay_size),
  .host_we(host_we), .host_last(host_last), .irq(irq), .drop_count(drop_count)
);

// File: tb/test_udp_stream_steer.sv
module test_udp_stream_steer;
  localparam int PORTS = 4;
  localparam int FIFO_AW = 11;
  localparam int DEPTH = 2048;
  localparam logic [47:0] MY_MAC = 48'h02_11_22_33_44_55;
  localparam logic [47:0] GRP_MAC = 48'h01_00_5E_01_02_03;
  localparam logic [47:0] OTHER_MAC = 48'h02_AA_BB_CC_DD_EE;
  localparam int HB = 'h1000, HS = 100, PB = 'h4000, PS = 300;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, rx_valid, rx_last, rx_err, cfg_we, cfg_en;
  logic [7:0] rx_data, irq_batch;
  logic [47:0] station_mac;
  logic [1:0] cfg_idx;
  logic [15:0] cfg_port, hdr_base, hdr_size, pay_base, pay_size;
  logic hdr_we, pay_we, host_we, host_last, irq;
  logic [15:0] hdr_addr, pay_addr, drop_count;
  logic [7:0] hdr_data, pay_data, host_data;

  udp_stream_steer #(.FIFO_AW(FIFO_AW), .QUEUE_AW(2), .PORTS(PORTS)) i_udp_stream_steer (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
    .rx_err(rx_err), .station_mac(station_mac), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_port(cfg_port), .cfg_en(cfg_en), .hdr_base(hdr_base), .hdr_size(hdr_size),
    .pay_base(pay_base), .pay_size(pay_size), .irq_batch(irq_batch),
    .hdr_we(hdr_we), .hdr_addr(hdr_addr), .hdr_data(hdr_data),
    .pay_we(pay_we), .pay_addr(pay_addr), .pay_data(pay_data),
    .host_we(host_we), .host_data(host_data), .host_last(host_last),
    .irq(irq), .drop_count(drop_count)
  );

  typedef logic [7:0] bq_t[$];
  typedef struct packed { logic [15:0] a; logic [7:0] d; } rw_t;

  rw_t hdr_q[$];
  rw_t pay_q[$];
  logic [8:0] host_q[$];
  int n_chk = 0, n_bad = 0, irq_seen = 0, exp_irq = 0, exp_drop = 0;
  int mb = 0, hoff = 0, poff = 0, batch = 3;
  logic [15:0] m_port[PORTS];
  bit m_en[PORTS];

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // output monitor: every emitted byte is compared with the model's next expectation
  always @(negedge clk) begin
    rw_t e;
    logic [8:0] h;
    if (rst_n) begin
      if (hdr_we) begin
        if (hdr_q.size() == 0) check("R4", "unexpected header write", 1, 0);
        else begin
          e = hdr_q.pop_front();
          check("R6", "header address", hdr_addr, e.a);
          check("R4", "header byte", hdr_data, e.d);
        end
      end
      if (pay_we) begin
        if (pay_q.size() == 0) check("R4", "unexpected payload write", 1, 0);
        else begin
          e = pay_q.pop_front();
          check("R6", "payload address", pay_addr, e.a);
          check("R4", "payload byte", pay_data, e.d);
        end
      end
      if (host_we) begin
        if (host_q.size() == 0) check("R5", "unexpected host byte", 1, 0);
        else begin
          h = host_q.pop_front();
          check("R5", "host byte", host_data, h[7:0]);
          check("R5", "host last flag", host_last, h[8]);
        end
      end
      if (irq) irq_seen++;
    end
  end

  function automatic bit port_on(input logic [15:0] p);
    for (int k = 0; k < PORTS; k++) if (m_en[k] && m_port[k] == p) return 1'b1;
    return 1'b0;
  endfunction

  task automatic model(input bq_t f, input bit err);
    int n;
    logic [47:0] d;
    bit off;
    n = f.size();
    if (n > DEPTH) begin exp_drop++; return; end
    if (err || n < 6) return;
    d = {f[0], f[1], f[2], f[3], f[4], f[5]};
    if (!(d == MY_MAC || f[0][0])) return;
    off = (n >= 42) && f[12] == 8'h08 && f[13] == 8'h00 && f[14] == 8'h45 &&
          f[23] == 8'h11 && port_on({f[36], f[37]});
    for (int i = 0; i < n; i++) begin
      if (!off) host_q.push_back({(i == n - 1), f[i]});
      else if (i < 42) begin
        hdr_q.push_back({16'(HB + hoff), f[i]});
        hoff = (hoff + 1 == HS) ? 0 : hoff + 1;
      end else begin
        pay_q.push_back({16'(PB + poff), f[i]});
        poff = (poff + 1 == PS) ? 0 : poff + 1;
      end
    end
    if (off) begin
      mb++;
      if (mb >= ((batch == 0) ? 1 : batch)) begin exp_irq++; mb = 0; end
    end
  endtask

  function automatic bq_t mk(input logic [47:0] dm, input logic [15:0] et, input logic [7:0] ver,
                             input logic [15:0] dp, input int plen, input int seed);
    bq_t f;
    for (int i = 0; i < 42 + plen; i++) f.push_back(8'((i * 13 + seed * 7) ^ (i >> 3)));
    for (int i = 0; i < 6; i++) f[i] = dm[8*(5-i) +: 8];
    f[12] = et[15:8]; f[13] = et[7:0]; f[14] = ver; f[23] = 8'h11;
    f[36] = dp[15:8]; f[37] = dp[7:0];
    return f;
  endfunction

  task automatic send(input bq_t f, input bit err);
    model(f, err);
    foreach (f[i]) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = f[i];
      rx_last = (i == f.size() - 1);
      rx_err = err && (i == f.size() - 1);
    end
  endtask

  task automatic settle(input string req);
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0; rx_err = 1'b0;
    for (int w = 0; w < 6000 && (hdr_q.size() + pay_q.size() + host_q.size()) != 0; w++)
      @(negedge clk);
    repeat (5) @(negedge clk);
    check(req, "header bytes still expected", hdr_q.size(), 0);
    check(req, "payload bytes still expected", pay_q.size(), 0);
    check(req, "host bytes still expected", host_q.size(), 0);
    check("R9", "interrupt pulses", irq_seen, exp_irq);
    check("R8", "dropped frame count", drop_count, exp_drop);
  endtask

  task automatic cfg(input int idx, input logic [15:0] p, input bit en);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_port = p; cfg_en = en;
    m_port[idx] = p; m_en[idx] = en;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R12 watchdog: actual hang expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    bq_t f;
    for (int k = 0; k < PORTS; k++) begin m_port[k] = '0; m_en[k] = 1'b0; end
    rst_n = 1'b0; rx_valid = 1'b0; rx_data = '0; rx_last = 1'b0; rx_err = 1'b0;
    cfg_we = 1'b0; cfg_idx = '0; cfg_port = '0; cfg_en = 1'b0;
    station_mac = MY_MAC; irq_batch = 8'd3;
    hdr_base = 16'(HB); hdr_size = 16'(HS); pay_base = 16'(PB); pay_size = 16'(PS);
    repeat (5) @(negedge clk);
    // R1: quiet outputs while in reset
    check("R1", "write strobes in reset", {hdr_we, pay_we, host_we}, 0);
    check("R1", "irq in reset", irq, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "drop count after reset", drop_count, 0);
    check("R1", "write strobes after reset", {hdr_we, pay_we, host_we, irq}, 0);

    // R10: table loaded through the configuration port
    cfg(0, 16'd5000, 1'b1);
    cfg(1, 16'd6000, 1'b1);
    cfg(2, 16'd7000, 1'b0);

    // R3 / R4: matching stream is split into the two rings
    send(mk(MY_MAC, 16'h0800, 8'h45, 16'd5000, 20, 1), 1'b0);
    settle("R4");
    // R5: other EtherType goes whole to the host path
    send(mk(MY_MAC, 16'h0806, 8'h45, 16'd5000, 10, 2), 1'b0);
    settle("R5");
    // R10: disabled entry does not match, enabling it does
    send(mk(MY_MAC, 16'h0800, 8'h45, 16'd7000, 8, 3), 1'b0);
    settle("R10");
    cfg(2, 16'd7000, 1'b1);
    send(mk(MY_MAC, 16'h0800, 8'h45, 16'd7000, 8, 4), 1'b0);
    settle("R10");
    // R2: foreign unicast dropped, group address accepted
    send(mk(OTHER_MAC, 16'h0800, 8'h45, 16'd5000, 8, 5), 1'b0);
    settle("R2");
    send(mk(GRP_MAC, 16'h0800, 8'h45, 16'd6000, 12, 6), 1'b0);
    settle("R2");
    // R7: error on the final byte cancels a matching frame
    send(mk(MY_MAC, 16'h0800, 8'h45, 16'd5000, 16, 7), 1'b1);
    settle("R7");
    // R3: IP options, wrong protocol and runt frames take the host path
    send(mk(MY_MAC, 16'h0800, 8'h46, 16'd5000, 6, 8), 1'b0);
    settle("R3");
    f = mk(MY_MAC, 16'h0800, 8'h45, 16'd5000, 6, 9);
    f[23] = 8'h06;
    send(f, 1'b0);
    settle("R3");
    f = mk(MY_MAC, 16'h0800, 8'h45, 16'd5000, 0, 10);
    f = f[0:29];
    send(f, 1'b0);
    settle("R3");
    // R4 / R6: full 1024-byte payload wraps the payload ring
    send(mk(MY_MAC, 16'h0800, 8'h45, 16'd6000, 1024, 11), 1'b0);
    settle("R6");
    // R12 / R11: back-to-back mixed burst
    send(mk(MY_MAC, 16'h0800, 8'h45, 16'd5000, 30, 12), 1'b0);
    send(mk(MY_MAC, 16'h86DD, 8'h60, 16'd5000, 5, 13), 1'b0);
    send(mk(MY_MAC, 16'h0800, 8'h45, 16'd5000, 25, 14), 1'b1);
    send(mk(GRP_MAC, 16'h0800, 8'h45, 16'd7000, 40, 15), 1'b0);
    send(mk(OTHER_MAC, 16'h0800, 8'h45, 16'd5000, 9, 16), 1'b0);
    send(mk(MY_MAC, 16'h0800, 8'h45, 16'd6000, 3, 17), 1'b0);
    settle("R12");
    // R8: frame larger than the store is dropped and counted, next one survives
    send(mk(MY_MAC, 16'h0800, 8'h45, 16'd5000, 2100 - 42, 18), 1'b0);
    settle("R8");
    send(mk(MY_MAC, 16'h0800, 8'h45, 16'd5000, 10, 19), 1'b0);
    settle("R8");
    // R9: batch of 1, then batch value 0 acting as 1
    @(negedge clk); irq_batch = 8'd1; batch = 1; mb = 0;
    send(mk(MY_MAC, 16'h0800, 8'h45, 16'd5000, 4, 20), 1'b0);
    settle("R9");
    @(negedge clk); irq_batch = 8'd0; batch = 0;
    send(mk(MY_MAC, 16'h0800, 8'h45, 16'd6000, 4, 21), 1'b0);
    send(mk(MY_MAC, 16'h0800, 8'h45, 16'd5000, 4, 22), 1'b0);
    settle("R9");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule